// File: doc/BRIEF.md
# Serial Port Register File with Divisor Banking

This block is the processor-side register decoder of a 16550-class serial port. It presents eight byte-wide locations behind a three-bit offset. It holds the control, status and divisor bytes with their reset values. It turns accesses to the data location into push, pop and flush strobes for the receive and transmit queues, which sit outside the block. The divisor-access bit, bit 7 of the line control byte, banks offsets 0 and 1. When that bit is set, those two offsets reach the low and high divisor bytes. When it is clear, they reach the queues and the interrupt-enable byte.

Each accepted access takes effect at one rising clock edge. Read data is registered and appears on the cycle after the read strobe, then holds until the next accepted read. The shifters, the baud generator and the modem pins live elsewhere. They take the divisor and the control bytes from the output ports.

Top module: `uart_regfile`

## Requirements
- R1: After reset, the bytes read back are: offset 1 = 0x03, offset 2 = 0x C0 written as 0xC0, offset 3 = 0x03, offset 4 = 0x00, offset 5 = 0x60, offset 6 = 0x00, offset 7 = 0x00. The divisor is 0x0001 (low byte 0x01, high byte 0x00).
- R2: When line control bit 7 is 1, offset 0 reads and writes the low divisor byte and offset 1 the high divisor byte. No queue strobe is raised. `div_value` shows {high, low}.
- R3: When line control bit 7 is 0, a write to offset 0 raises `tx_push` for that cycle with `tx_byte` equal to the written byte. No register changes.
- R4: When line control bit 7 is 0 and the receive queue is not empty, a read of offset 0 raises `rx_pop` in that cycle. The next `bus_rdata` equals `rx_head`.
- R5: A read of offset 0 (bit 7 clear) while `rx_empty` is 1 raises no `rx_pop` and returns 0x00.
- R6: When line control bit 7 is 0, offset 1 reads and writes the interrupt-enable byte.
- R7: A write to offset 2 with bit 0 = 1 stores the whole byte. It pulses `rx_flush` if bit 1 is set and `tx_flush` if bit 2 is set.
- R8: A write to offset 2 with bit 0 = 0 pulses both `rx_flush` and `tx_flush`. It clears only bit 0 of the stored byte.
- R9: A read of offset 2 returns the stored FIFO-control byte.
- R10: A read of offset 5 returns the line-status byte and then clears only its bit 1 (overrun). An `rx_overrun` pulse sets bit 1, and it wins over a same-cycle clear or write.
- R11: Offsets 3, 4 and 7 are plain read/write bytes. Offsets 5 and 6 accept direct writes.
- R12: When write and read strobes arrive in the same cycle, only the write is accepted. No pop occurs and `bus_rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| rx_head | input | 8 | Oldest byte of the receive queue |
| rx_empty | input | 1 | Receive queue holds nothing |
| rx_overrun | input | 1 | Receive queue dropped a byte |
| rx_pop | output | 1 | Remove the oldest receive byte |
| rx_flush | output | 1 | Empty the receive queue |
| tx_byte | output | 8 | Byte to append to the transmit queue |
| tx_push | output | 1 | Append `tx_byte` to the transmit queue |
| tx_flush | output | 1 | Empty the transmit queue |
| div_value | output | 16 | Baud divisor {high, low} |
| line_ctrl | output | 8 | Line control byte |
| modem_ctrl | output | 8 | Modem control byte |
| int_enable | output | 8 | Interrupt-enable byte |
| fifo_ctrl | output | 8 | Stored FIFO-control byte |

## Verification
The data offset is driven with the banking bit both set and clear, and with the receive queue full and empty. This separates divisor access from queue traffic, and a genuine pop from an empty read that must yield zero. The FIFO-control writes cover enable-with-one-flush, enable-with-the-other-flush and enable-clear values. These distinguish selective flushing from the flush-both path, and also show that disable keeps the upper bits. Overrun pulses are placed before a status read, during one and on top of a direct status write. This tells the ordering of set, write and read-clear apart. A same-cycle write and read on the data offset checks that the read is dropped.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  localparam int RF_BYTE = 8;
  localparam int RF_AW   = 3;
  localparam int RF_NLOC = 1 << RF_AW;

  // offsets whose position the decode depends on
  localparam logic [RF_AW-1:0] OFS_DATA  = 3'd0;
  localparam logic [RF_AW-1:0] OFS_IEN   = 3'd1;
  localparam logic [RF_AW-1:0] OFS_FIFO  = 3'd2;
  localparam logic [RF_AW-1:0] OFS_LINE  = 3'd3;
  localparam logic [RF_AW-1:0] OFS_MODEM = 3'd4;
  localparam logic [RF_AW-1:0] OFS_LSTAT = 3'd5;
  localparam logic [RF_AW-1:0] OFS_MSTAT = 3'd6;
  localparam logic [RF_AW-1:0] OFS_SCR   = 3'd7;

  localparam int BANK_BIT    = 7;
  localparam int OVERRUN_BIT = 1;

  localparam logic [RF_BYTE-1:0] RST_IEN   = 8'h03;
  localparam logic [RF_BYTE-1:0] RST_FIFO  = 8'hC0;
  localparam logic [RF_BYTE-1:0] RST_LINE  = 8'h03;
  localparam logic [RF_BYTE-1:0] RST_MODEM = 8'h00;
  localparam logic [RF_BYTE-1:0] RST_LSTAT = 8'h60;
  localparam logic [RF_BYTE-1:0] RST_MSTAT = 8'h00;
  localparam logic [RF_BYTE-1:0] RST_SCR   = 8'h00;
  localparam logic [RF_BYTE-1:0] RST_DIVLO = 8'h01;
  localparam logic [RF_BYTE-1:0] RST_DIVHI = 8'h00;

  typedef struct packed {
    logic push;
    logic pop;
    logic data_rd;
    logic div_lo_wr;
    logic div_hi_wr;
    logic ien_wr;
    logic fifo_wr;
    logic line_wr;
    logic modem_wr;
    logic lstat_wr;
    logic lstat_rd;
    logic mstat_wr;
    logic scr_wr;
    logic rd_take;
  } rf_sel_t;

  // FIFO-control byte after a write: kept whole when enabled, else only bit 0 drops
  function automatic logic [RF_BYTE-1:0] fifo_after_write(
      input logic [RF_BYTE-1:0] cur, input logic [RF_BYTE-1:0] wv);
    return wv[0] ? wv : {cur[RF_BYTE-1:1], 1'b0};
  endfunction

  // flush pair {rx, tx} requested by a FIFO-control byte
  function automatic logic [1:0] flush_request(input logic [RF_BYTE-1:0] wv);
    return wv[0] ? {wv[1], wv[2]} : 2'b11;
  endfunction

  // line status: read clears overrun, a write replaces, overrun event sets last
  function automatic logic [RF_BYTE-1:0] lstat_next(
      input logic [RF_BYTE-1:0] cur, input logic wr, input logic [RF_BYTE-1:0] wv,
      input logic rd, input logic ovr);
    logic [RF_BYTE-1:0] v;
    v = cur;
    if (rd) v[OVERRUN_BIT] = 1'b0;
    if (wr) v = wv;
    if (ovr) v[OVERRUN_BIT] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
#(
  parameter int AW = RF_AW
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic          bank,
  input  logic          rx_empty,
  output rf_sel_t       sel
);
  localparam int NLOC = 1 << AW;

  logic [NLOC-1:0] hit;
  logic            acc_wr;
  logic            acc_rd;

  for (genvar g = 0; g < NLOC; g++) begin : g_hit
    assign hit[g] = (addr == AW'(g));
  end

  assign acc_wr = wr;
  assign acc_rd = rd & ~wr;

  always_comb begin
    sel           = '0;
    sel.rd_take   = acc_rd;
    sel.push      = acc_wr & hit[OFS_DATA] & ~bank;
    sel.div_lo_wr = acc_wr & hit[OFS_DATA] & bank;
    sel.div_hi_wr = acc_wr & hit[OFS_IEN] & bank;
    sel.ien_wr    = acc_wr & hit[OFS_IEN] & ~bank;
    sel.fifo_wr   = acc_wr & hit[OFS_FIFO];
    sel.line_wr   = acc_wr & hit[OFS_LINE];
    sel.modem_wr  = acc_wr & hit[OFS_MODEM];
    sel.lstat_wr  = acc_wr & hit[OFS_LSTAT];
    sel.mstat_wr  = acc_wr & hit[OFS_MSTAT];
    sel.scr_wr    = acc_wr & hit[OFS_SCR];
    sel.data_rd   = acc_rd & hit[OFS_DATA] & ~bank;
    sel.pop       = acc_rd & hit[OFS_DATA] & ~bank & ~rx_empty;
    sel.lstat_rd  = acc_rd & hit[OFS_LSTAT];
  end
endmodule

// File: rtl/uart_rf_bank.sv
module uart_rf_bank
  import uart_rf_pkg::*;
#(
  parameter int DW = RF_BYTE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rf_sel_t       sel,
  input  logic [DW-1:0] wdata,
  input  logic          ovr,
  output logic [DW-1:0] ien_q,
  output logic [DW-1:0] fifo_q,
  output logic [DW-1:0] line_q,
  output logic [DW-1:0] modem_q,
  output logic [DW-1:0] lstat_q,
  output logic [DW-1:0] mstat_q,
  output logic [DW-1:0] scr_q,
  output logic [DW-1:0] divlo_q,
  output logic [DW-1:0] divhi_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q   <= RST_IEN;
      fifo_q  <= RST_FIFO;
      line_q  <= RST_LINE;
      modem_q <= RST_MODEM;
      lstat_q <= RST_LSTAT;
      mstat_q <= RST_MSTAT;
      scr_q   <= RST_SCR;
      divlo_q <= RST_DIVLO;
      divhi_q <= RST_DIVHI;
    end else begin
      if (sel.ien_wr)    ien_q   <= wdata;
      if (sel.fifo_wr)   fifo_q  <= fifo_after_write(fifo_q, wdata);
      if (sel.line_wr)   line_q  <= wdata;
      if (sel.modem_wr)  modem_q <= wdata;
      if (sel.mstat_wr)  mstat_q <= wdata;
      if (sel.scr_wr)    scr_q   <= wdata;
      if (sel.div_lo_wr) divlo_q <= wdata;
      if (sel.div_hi_wr) divhi_q <= wdata;
      lstat_q <= lstat_next(lstat_q, sel.lstat_wr, wdata, sel.lstat_rd, ovr);
    end
  end
endmodule

// File: rtl/uart_rf_rdmux.sv
module uart_rf_rdmux
  import uart_rf_pkg::*;
#(
  parameter int DW = RF_BYTE,
  parameter int AW = RF_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rf_sel_t       sel,
  input  logic [AW-1:0] addr,
  input  logic          bank,
  input  logic [DW-1:0] rx_head,
  input  logic [DW-1:0] ien_q,
  input  logic [DW-1:0] fifo_q,
  input  logic [DW-1:0] line_q,
  input  logic [DW-1:0] modem_q,
  input  logic [DW-1:0] lstat_q,
  input  logic [DW-1:0] mstat_q,
  input  logic [DW-1:0] scr_q,
  input  logic [DW-1:0] divlo_q,
  input  logic [DW-1:0] divhi_q,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] pick;

  always_comb begin
    unique case (addr)
      OFS_DATA:  pick = bank ? divlo_q : (sel.pop ? rx_head : '0);
      OFS_IEN:   pick = bank ? divhi_q : ien_q;
      OFS_FIFO:  pick = fifo_q;
      OFS_LINE:  pick = line_q;
      OFS_MODEM: pick = modem_q;
      OFS_LSTAT: pick = lstat_q;
      OFS_MSTAT: pick = mstat_q;
      default:   pick = scr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rdata <= '0;
    else if (sel.rd_take) rdata <= pick;
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [7:0]   bus_wdata,
  output logic [7:0]   bus_rdata,
  input  logic [7:0]   rx_head,
  input  logic         rx_empty,
  input  logic         rx_overrun,
  output logic         rx_pop,
  output logic         rx_flush,
  output logic [7:0]   tx_byte,
  output logic         tx_push,
  output logic         tx_flush,
  output logic [15:0]  div_value,
  output logic [7:0]   line_ctrl,
  output logic [7:0]   modem_ctrl,
  output logic [7:0]   int_enable,
  output logic [7:0]   fifo_ctrl
);
  rf_sel_t            sel;
  logic [RF_BYTE-1:0] ien_q, fifo_q, line_q, modem_q, lstat_q, mstat_q, scr_q;
  logic [RF_BYTE-1:0] divlo_q, divhi_q;
  logic               bank;
  logic [1:0]         flush_pair;

  assign bank = line_q[BANK_BIT];

  uart_rf_decode #(.AW(RF_AW)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .bank(bank),
    .rx_empty(rx_empty), .sel(sel)
  );

  uart_rf_bank #(.DW(RF_BYTE)) u_bank (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wdata(bus_wdata), .ovr(rx_overrun),
    .ien_q(ien_q), .fifo_q(fifo_q), .line_q(line_q), .modem_q(modem_q),
    .lstat_q(lstat_q), .mstat_q(mstat_q), .scr_q(scr_q),
    .divlo_q(divlo_q), .divhi_q(divhi_q)
  );

  uart_rf_rdmux #(.DW(RF_BYTE), .AW(RF_AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(bus_addr), .bank(bank),
    .rx_head(rx_head), .ien_q(ien_q), .fifo_q(fifo_q), .line_q(line_q),
    .modem_q(modem_q), .lstat_q(lstat_q), .mstat_q(mstat_q), .scr_q(scr_q),
    .divlo_q(divlo_q), .divhi_q(divhi_q), .rdata(bus_rdata)
  );

  assign flush_pair = flush_request(bus_wdata);
  assign rx_flush   = sel.fifo_wr & flush_pair[1];
  assign tx_flush   = sel.fifo_wr & flush_pair[0];
  assign rx_pop     = sel.pop;
  assign tx_push    = sel.push;
  assign tx_byte    = bus_wdata;
  assign div_value  = {divhi_q, divlo_q};
  assign line_ctrl  = line_q;
  assign modem_ctrl = modem_q;
  assign int_enable = ien_q;
  assign fifo_ctrl  = fifo_q;
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  bus_rdata,
  input logic [7:0]  rx_head,
  input logic        rx_empty,
  input logic        rx_overrun,
  input logic        rx_pop,
  input logic        rx_flush,
  input logic [7:0]  tx_byte,
  input logic        tx_push,
  input logic        tx_flush,
  input logic [7:0]  line_ctrl,
  input logic [7:0]  fifo_ctrl,
  input logic [7:0]  lstat_q
);
  a_r2_bank_blocks_queues: assert property (@(posedge clk) disable iff (!rst_n)
    line_ctrl[7] |-> (!tx_push && !rx_pop));

  a_r3_push_carries_byte: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> (bus_wr && tx_byte == bus_wdata));

  a_r4_pop_returns_head: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |=> (bus_rdata == $past(rx_head)));

  a_r5_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> !rx_pop);

  a_r8_disable_flushes_both: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd2 && !bus_wdata[0]) |-> (rx_flush && tx_flush));

  a_r9_fifo_byte_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd2 && bus_wdata[0]) |=> (fifo_ctrl == $past(bus_wdata)));

  a_r10_read_clears_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 3'd5 && !rx_overrun) |=> !lstat_q[1]);

  a_r10_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> lstat_q[1]);

  a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_rd) |=> $stable(bus_rdata));
endmodule

bind uart_regfile uart_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_head(rx_head),
  .rx_empty(rx_empty), .rx_overrun(rx_overrun), .rx_pop(rx_pop),
  .rx_flush(rx_flush), .tx_byte(tx_byte), .tx_push(tx_push), .tx_flush(tx_flush),
  .line_ctrl(line_ctrl), .fifo_ctrl(fifo_ctrl), .lstat_q(lstat_q)
);

// File: tb/uart_regfile_test.sv
`timescale 1ns/1ps
module uart_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  rx_head = 8'hEE;
  logic        rx_empty = 1'b1;
  logic        rx_overrun = 1'b0;
  logic        rx_pop, rx_flush, tx_push, tx_flush;
  logic [7:0]  tx_byte, line_ctrl, modem_ctrl, int_enable, fifo_ctrl;
  logic [15:0] div_value;

  always #5 clk = ~clk;

  uart_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_head(rx_head),
    .rx_empty(rx_empty), .rx_overrun(rx_overrun), .rx_pop(rx_pop),
    .rx_flush(rx_flush), .tx_byte(tx_byte), .tx_push(tx_push), .tx_flush(tx_flush),
    .div_value(div_value), .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl),
    .int_enable(int_enable), .fifo_ctrl(fifo_ctrl)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference state
  byte unsigned m_ien = 8'h03, m_fifo = 8'hC0, m_line = 8'h03, m_modem = 8'h00;
  byte unsigned m_lstat = 8'h60, m_mstat = 8'h00, m_scr = 8'h00;
  byte unsigned m_dlo = 8'h01, m_dhi = 8'h00, m_rd = 8'h00;
  byte unsigned rxq[$];

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic feed_rx();
    rx_empty = (rxq.size() == 0);
    rx_head  = (rxq.size() == 0) ? 8'hEE : rxq[0];
  endtask

  task automatic access(input bit we, input bit re, input bit [2:0] a,
                        input byte unsigned d, input bit ovr, input string tag);
    bit bank, e_push, e_pop, e_rxf, e_txf, take;
    byte unsigned pick;
    @(negedge clk);
    bus_wr = we; bus_rd = re; bus_addr = a; bus_wdata = d; rx_overrun = ovr;
    #1;
    bank   = m_line[7];
    take   = re && !we;
    e_push = we && a == 3'd0 && !bank;
    e_pop  = take && a == 3'd0 && !bank && rxq.size() > 0;
    e_rxf  = we && a == 3'd2 && (!d[0] || d[1]);
    e_txf  = we && a == 3'd2 && (!d[0] || d[2]);
    check({tag, " strobes"}, {rx_pop, tx_push, rx_flush, tx_flush},
          {e_pop, e_push, e_rxf, e_txf});
    if (e_push) check({tag, " tx_byte"}, tx_byte, d);
    case (a)
      3'd0: pick = bank ? m_dlo : (e_pop ? rxq[0] : 8'h00);
      3'd1: pick = bank ? m_dhi : m_ien;
      3'd2: pick = m_fifo;
      3'd3: pick = m_line;
      3'd4: pick = m_modem;
      3'd5: pick = m_lstat;
      3'd6: pick = m_mstat;
      default: pick = m_scr;
    endcase
    @(posedge clk);
    if (take) m_rd = pick;
    if (take && a == 3'd5) m_lstat[1] = 1'b0;
    if (we) begin
      case (a)
        3'd0: if (bank) m_dlo = d;
        3'd1: if (bank) m_dhi = d; else m_ien = d;
        3'd2: m_fifo = d[0] ? d : {m_fifo[7:1], 1'b0};
        3'd3: m_line = d;
        3'd4: m_modem = d;
        3'd5: m_lstat = d;
        3'd6: m_mstat = d;
        default: m_scr = d;
      endcase
    end
    if (ovr) m_lstat[1] = 1'b1;
    if (e_pop) void'(rxq.pop_front());
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; rx_overrun = 0;
    feed_rx();
    check({tag, " rdata"}, bus_rdata, m_rd);
    check({tag, " divisor"}, div_value, {m_dhi, m_dlo});
    check({tag, " ctrl"}, {line_ctrl, modem_ctrl, int_enable, fifo_ctrl},
          {m_line, m_modem, m_ien, m_fifo});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset values
    check("R1 rdata reset", bus_rdata, 0);
    for (int i = 1; i < 8; i++) access(0, 1, 3'(i), 0, 0, "R1 reset read");
    // R2 divisor banking
    access(1, 0, 3'd3, 8'h83, 0, "R11 line write");
    access(0, 1, 3'd0, 0, 0, "R2 div lo reset");
    access(0, 1, 3'd1, 0, 0, "R2 div hi reset");
    rxq.push_back(8'h99); feed_rx();
    access(1, 0, 3'd0, 8'h34, 0, "R2 div lo write");
    access(1, 0, 3'd1, 8'h12, 0, "R2 div hi write");
    access(0, 1, 3'd0, 0, 0, "R2 div lo read no pop");
    access(0, 1, 3'd1, 0, 0, "R2 div hi read");
    access(1, 0, 3'd3, 8'h03, 0, "R11 line restore");
    // R3 push, R4 pop, R5 empty
    access(1, 0, 3'd0, 8'h41, 0, "R3 push");
    access(1, 0, 3'd0, 8'hBE, 0, "R3 push second");
    rxq.push_back(8'h5A); rxq.push_back(8'hA5); feed_rx();
    access(0, 1, 3'd0, 0, 0, "R4 pop 1");
    access(0, 1, 3'd0, 0, 0, "R4 pop 2");
    access(0, 1, 3'd0, 0, 0, "R4 pop 3");
    access(0, 1, 3'd0, 0, 0, "R5 empty read");
    // R6 interrupt enable
    access(1, 0, 3'd1, 8'h0F, 0, "R6 ien write");
    access(0, 1, 3'd1, 0, 0, "R6 ien read");
    // R7/R8/R9 FIFO control
    access(1, 0, 3'd2, 8'h07, 0, "R7 flush both enabled");
    access(0, 1, 3'd2, 0, 0, "R9 fifo read");
    access(1, 0, 3'd2, 8'h43, 0, "R7 rx flush only");
    access(1, 0, 3'd2, 8'hC5, 0, "R7 tx flush only");
    access(1, 0, 3'd2, 8'h81, 0, "R7 no flush");
    access(1, 0, 3'd2, 8'h3A, 0, "R8 disable");
    access(0, 1, 3'd2, 0, 0, "R9 fifo read after disable");
    // R10 line status
    access(0, 0, 3'd0, 0, 1, "R10 overrun event");
    access(0, 1, 3'd5, 0, 0, "R10 read with overrun");
    access(0, 1, 3'd5, 0, 0, "R10 read cleared");
    access(1, 0, 3'd5, 8'hFF, 0, "R11 lstat write");
    access(0, 1, 3'd5, 0, 0, "R10 read all set");
    access(0, 1, 3'd5, 0, 0, "R10 only overrun cleared");
    access(0, 1, 3'd5, 0, 1, "R10 overrun during read");
    access(0, 1, 3'd5, 0, 0, "R10 overrun kept");
    access(1, 0, 3'd5, 8'h00, 1, "R10 overrun over write");
    access(0, 1, 3'd5, 0, 0, "R10 set wins");
    // R11 plain storage
    access(1, 0, 3'd4, 8'h1B, 0, "R11 modem write");
    access(1, 0, 3'd6, 8'hF0, 0, "R11 mstat write");
    access(1, 0, 3'd7, 8'hC3, 0, "R11 scratch write");
    access(1, 0, 3'd3, 8'h1F, 0, "R11 line write");
    for (int i = 3; i < 8; i++) access(0, 1, 3'(i), 0, 0, "R11 readback");
    // R12 write and read together
    rxq.push_back(8'h77); feed_rx();
    access(1, 1, 3'd0, 8'h66, 0, "R12 both strobes data");
    access(1, 1, 3'd7, 8'h24, 0, "R12 both strobes scratch");
    access(0, 1, 3'd0, 0, 0, "R12 queue untouched");
    access(0, 1, 3'd7, 0, 0, "R12 write accepted");
    finish_run();
  end
endmodule